// File: doc/BRIEF.md
# Single-Pending Event Interrupt Controller

This block collects six event sources of a bus-attached peripheral and reports them to an external master over one active-low interrupt line. The master programs an 8-bit enable byte, and each source is gated by one bit of it. The block presents exactly one event at a time in an 8-bit status byte. A status read strobe from the master clears the presented event. Other enabled events wait in a pending set until the line is free.

While the master has a register read outstanding, the block presents nothing new except the data-ready event, so the next interrupt the master sees after starting a read means its data is available. The FIFO event is edge-triggered: it fires when any OUT FIFO goes from empty to not-empty. The other five sources are single-cycle pulses.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset the interrupt output is high, the status byte is 0x00 and every source is disabled.
- R2: Status byte bit positions are: setup-packet 7, control-buffer 6, FIFO 5, configured 4, bus-activity 3, data-ready 2. Bits 1 and 0 always read 0, and at most one bit of the byte is set.
- R3: A write of the enable byte sets per-source enables at the same bit positions as the status byte. The new value applies to events sampled from the cycle after the write.
- R4: An enabled event sampled at clock edge k drives the interrupt output low after edge k+1, provided the output was free and no higher-priority event was waiting. At that time the matching status bit is set.
- R5: A read strobe sampled while an interrupt is presented clears it. The output is high for at least the following cycle.
- R6: A presented status byte does not change until it is read, and further events stay pending meanwhile.
- R7: When the output is free, the waiting source with the highest status bit is presented first.
- R8: Repeated occurrences of a source that is already pending merge into one presentation.
- R9: The FIFO event fires on a rising edge of any OUT FIFO not-empty input. A not-empty input that stays high does not fire it again.
- R10: While the register-read-busy input is high, only the data-ready event may become presented. Other pending events wait until busy falls.
- R11: Events arriving for a disabled source are dropped, so enabling that source later raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr_i | input | 1 | Enable byte write strobe |
| en_data_i | input | 8 | Enable byte value |
| setup_evt_i | input | 1 | Setup-packet event pulse |
| ep0buf_evt_i | input | 1 | Control buffer available pulse |
| enumok_evt_i | input | 1 | Configuration done pulse |
| busact_evt_i | input | 1 | Bus activity pulse |
| ready_evt_i | input | 1 | Register read data ready pulse |
| fifo_ne_i | input | NUM_OUT_FIFO | Not-empty level of each OUT FIFO |
| rd_busy_i | input | 1 | Master register read outstanding |
| rd_stb_i | input | 1 | Status byte read strobe |
| int_n_o | output | 1 | Active-low interrupt |
| status_o | output | 8 | Status byte, one bit set for the presented event |

## Verification
The assertions check on every cycle that the status byte keeps its two low bits at zero and at most one bit set. They also check that a presented byte stays stable until it is read, that a read frees the line, and that only data-ready can be presented while a read is busy. Only the bench scenarios can show the rest: the priority order, the merging of repeats, the dropping of disabled events, and the edge detection on the FIFO inputs. In those scenarios a behavioural model tracks the pending set and the presented source on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_N   = 6;
    localparam int STAT_W  = 8;
    localparam int SRC_LSB = STAT_W - SRC_N;

    localparam int SRC_READY  = 0;
    localparam int SRC_BUSACT = 1;
    localparam int SRC_ENUMOK = 2;
    localparam int SRC_FLAGS  = 3;
    localparam int SRC_EP0BUF = 4;
    localparam int SRC_SETUP  = 5;

    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irqc_rise_any.sv
module irqc_rise_any #(
    parameter int W = 2
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    output logic         rise_o
);
    logic [W-1:0] rise_bits;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise_bits[g] = cur_i[g] & ~prev_i[g];
    end

    assign rise_o = |rise_bits;
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import irqc_pkg::*;
#(
    parameter int NUM_OUT_FIFO = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_wr_i,
    input  logic [STAT_W-1:0]       en_data_i,
    input  logic                    setup_evt_i,
    input  logic                    ep0buf_evt_i,
    input  logic                    enumok_evt_i,
    input  logic                    busact_evt_i,
    input  logic                    ready_evt_i,
    input  logic [NUM_OUT_FIFO-1:0] fifo_ne_i,
    input  logic                    rd_busy_i,
    input  logic                    rd_stb_i,
    output logic                    int_n_o,
    output logic [STAT_W-1:0]       status_o
);
    typedef struct packed {
        src_vec_t                en;
        src_vec_t                pend;
        src_vec_t                cur;
        logic [NUM_OUT_FIFO-1:0] ne;
    } state_t;

    state_t   st_q, st_d;
    logic     fifo_rise;
    src_vec_t raw_evt, hit, allow, grant;
    logic     grant_any;

    irqc_rise_any #(.W(NUM_OUT_FIFO)) u_rise (
        .cur_i (fifo_ne_i),
        .prev_i(st_q.ne),
        .rise_o(fifo_rise)
    );

    always_comb begin
        raw_evt             = '0;
        raw_evt[SRC_SETUP]  = setup_evt_i;
        raw_evt[SRC_EP0BUF] = ep0buf_evt_i;
        raw_evt[SRC_FLAGS]  = fifo_rise;
        raw_evt[SRC_ENUMOK] = enumok_evt_i;
        raw_evt[SRC_BUSACT] = busact_evt_i;
        raw_evt[SRC_READY]  = ready_evt_i;
        hit = raw_evt & st_q.en;
        if (rd_busy_i) begin
            allow            = '0;
            allow[SRC_READY] = 1'b1;
        end else begin
            allow = '1;
        end
    end

    irqc_prio_pick #(.N(SRC_N)) u_pick (
        .req_i  (st_q.pend & allow),
        .grant_o(grant),
        .any_o  (grant_any)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ne = fifo_ne_i;
        if (en_wr_i) begin
            st_d.en = en_data_i[STAT_W-1:SRC_LSB];
        end
        if (st_q.cur != '0) begin
            if (rd_stb_i) begin
                st_d.cur = '0;
            end
        end else if (grant_any) begin
            st_d.cur  = grant;
            st_d.pend = st_q.pend & ~grant;
        end
        st_d.pend = st_d.pend | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_n_o  = ~|st_q.cur;
    assign status_o = {st_q.cur, {SRC_LSB{1'b0}}};
endmodule

module evt_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb_i,
    input logic       rd_busy_i,
    input logic       int_n_o,
    input logic [7:0] status_o
);
    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1:0] == 2'b00);

    assert_single_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_o));

    assert_read_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !int_n_o) |=> int_n_o);

    assert_hold_until_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_i && !int_n_o) |=> $stable(status_o));

    assert_busy_only_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy_i && int_n_o) |=> (int_n_o || status_o == 8'h04));
endmodule

bind evt_irq_unit evt_irq_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb_i (rd_stb_i),
    .rd_busy_i(rd_busy_i),
    .int_n_o  (int_n_o),
    .status_o (status_o)
);

// File: tb/evt_irq_unit_bench.sv
module evt_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr_i = 1'b0;
    logic [7:0] en_data_i = 8'h00;
    logic       setup_evt_i = 1'b0, ep0buf_evt_i = 1'b0, enumok_evt_i = 1'b0;
    logic       busact_evt_i = 1'b0, ready_evt_i = 1'b0;
    logic [1:0] fifo_ne_i = 2'b00;
    logic       rd_busy_i = 1'b0, rd_stb_i = 1'b0;
    logic       int_n_o;
    logic [7:0] status_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural model: status bit number of the presented source, -1 if none
    int  m_cur = -1;
    bit  m_pend [8];
    bit  m_en [8];
    bit [1:0] m_ne = 2'b00;

    evt_irq_unit u_evt_irq_unit (
        .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_data_i(en_data_i),
        .setup_evt_i(setup_evt_i), .ep0buf_evt_i(ep0buf_evt_i),
        .enumok_evt_i(enumok_evt_i), .busact_evt_i(busact_evt_i),
        .ready_evt_i(ready_evt_i), .fifo_ne_i(fifo_ne_i),
        .rd_busy_i(rd_busy_i), .rd_stb_i(rd_stb_i),
        .int_n_o(int_n_o), .status_o(status_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit ev [8];
        cycles++;
        if (!rst_n) begin
            m_cur = -1;
            m_ne  = 2'b00;
            for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_en[i] = 0; end
        end else begin
            for (int i = 0; i < 8; i++) ev[i] = 0;
            ev[7] = setup_evt_i; ev[6] = ep0buf_evt_i;
            ev[5] = |(fifo_ne_i & ~m_ne);
            ev[4] = enumok_evt_i; ev[3] = busact_evt_i; ev[2] = ready_evt_i;
            if (m_cur >= 0) begin
                if (rd_stb_i) m_cur = -1;
            end else begin
                for (int b = 7; b >= 2; b--) begin
                    if (m_cur < 0 && m_pend[b] && (!rd_busy_i || b == 2)) begin
                        m_cur = b;
                        m_pend[b] = 0;
                    end
                end
            end
            for (int i = 2; i < 8; i++) if (ev[i] && m_en[i]) m_pend[i] = 1;
            if (en_wr_i) for (int i = 2; i < 8; i++) m_en[i] = en_data_i[i];
            m_ne = fifo_ne_i;
        end
        #2;
        if (rst_n) begin
            logic [7:0] es;
            es = (m_cur >= 0) ? (8'h01 << m_cur) : 8'h00;
            check(tag, {int_n_o, status_o}, {(m_cur < 0), es});
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired in %s", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_en(input logic [7:0] v);
        @(negedge clk); en_wr_i = 1'b1; en_data_i = v;
        @(negedge clk); en_wr_i = 1'b0;
    endtask

    task automatic read_status(input logic [7:0] exp);
        int n;
        n = 0;
        while (int_n_o && n < 50) begin @(negedge clk); n++; end
        check(tag, {1'b0, status_o}, {1'b0, exp});
        rd_stb_i = 1'b1;
        @(negedge clk); rd_stb_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {int_n_o, status_o}, {1'b1, 8'h00});
        rst_n = 1'b1;
        // R1: no source enabled, events ignored
        @(negedge clk); setup_evt_i = 1'b1;
        @(negedge clk); setup_evt_i = 1'b0;
        idle(3);
        check("R1", {int_n_o, status_o}, {1'b1, 8'h00});

        tag = "R3";
        write_en(8'hFC);
        tag = "R4";
        setup_evt_i = 1'b1;
        @(negedge clk); setup_evt_i = 1'b0;
        check("R4", {8'h00, int_n_o}, 9'h001);
        @(negedge clk);
        check("R4", {int_n_o, status_o}, {1'b0, 8'h80});
        tag = "R5";
        read_status(8'h80);
        check("R5", {8'h00, int_n_o}, 9'h001);

        tag = "R7";
        enumok_evt_i = 1'b1; ready_evt_i = 1'b1; ep0buf_evt_i = 1'b1;
        @(negedge clk); enumok_evt_i = 1'b0; ready_evt_i = 1'b0; ep0buf_evt_i = 1'b0;
        idle(3);
        tag = "R6";
        check("R6", {1'b0, status_o}, {1'b0, 8'h40});
        tag = "R7";
        read_status(8'h40);
        read_status(8'h10);
        read_status(8'h04);

        tag = "R8";
        setup_evt_i = 1'b1;
        @(negedge clk); setup_evt_i = 1'b0; busact_evt_i = 1'b1;
        @(negedge clk); busact_evt_i = 1'b0;
        @(negedge clk); busact_evt_i = 1'b1;
        @(negedge clk); busact_evt_i = 1'b0;
        read_status(8'h80);
        read_status(8'h08);
        idle(4);
        check("R8", {int_n_o, status_o}, {1'b1, 8'h00});

        tag = "R11";
        write_en(8'hBC);
        ep0buf_evt_i = 1'b1;
        @(negedge clk); ep0buf_evt_i = 1'b0;
        write_en(8'hFC);
        idle(4);
        check("R11", {int_n_o, status_o}, {1'b1, 8'h00});

        tag = "R9";
        fifo_ne_i = 2'b01;
        read_status(8'h20);
        idle(4);
        check("R9", {int_n_o, status_o}, {1'b1, 8'h00});
        fifo_ne_i = 2'b11;
        read_status(8'h20);
        fifo_ne_i = 2'b00;
        idle(4);
        check("R9", {int_n_o, status_o}, {1'b1, 8'h00});

        tag = "R10";
        rd_busy_i = 1'b1;
        setup_evt_i = 1'b1; busact_evt_i = 1'b1;
        @(negedge clk); setup_evt_i = 1'b0; busact_evt_i = 1'b0;
        idle(5);
        check("R10", {int_n_o, status_o}, {1'b1, 8'h00});
        ready_evt_i = 1'b1;
        @(negedge clk); ready_evt_i = 1'b0;
        read_status(8'h04);
        idle(2);
        check("R10", {int_n_o, status_o}, {1'b1, 8'h00});
        rd_busy_i = 1'b0;
        read_status(8'h80);
        read_status(8'h08);

        tag = "R2";
        write_en(8'hFF);
        busact_evt_i = 1'b1;
        @(negedge clk); busact_evt_i = 1'b0;
        read_status(8'h08);
        idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule